// File: doc/BRIEF.md
# Warp Instruction Issue Router

This block takes the oldest instructions waiting in one warp's instruction buffer and decides, within a single clock cycle, which of them leave for an execution pipeline. There are four pipelines: single-precision ALU, double-precision, special-function and memory. Each instruction carries an operation class. The class, together with the free input slots each pipeline reports, decides where the instruction goes and whether it can go at all. Issue is strictly in order. The first instruction that cannot issue stops the warp for that cycle, and so do a waiting warp, an exhausted buffer or the configured per-cycle issue limit.

The buffer head window is presented at the ports, one entry per issue slot, with a thermometer-coded valid vector. The block answers in the same cycle with a pop count, so the buffer can advance at the clock edge. On that same edge the block registers, for every slot, an issue strobe with the target pipe code, the instruction payload and the warp's active mask. A configuration count of double-precision units decides whether double-precision work has its own pipe or falls back to the special-function pipe. An optional mode forbids two consecutive issues in a cycle from landing on the same unit type.

Top module: `warp_issue_router`

## Requirements
- R1: Operation class 0 (plain ALU) and the reserved classes 5 to 7 are routed to the single-precision pipe (unit code 0). Class 4 (memory) is routed to the memory pipe (unit code 3).
- R2: Class 3 (double precision) is routed to the double-precision pipe (unit code 1) when `dp_unit_count` is non-zero.
- R3: When `dp_unit_count` is zero, class 3 is routed to the special-function pipe (unit code 2), whatever the double-precision pipe's free count. Class 1 (special function) always goes to unit code 2.
- R4: Class 2 (combined ALU/special function) goes to the single-precision pipe when that pipe has a slot left and the same-unit rule allows it. Otherwise it goes to the special-function pipe.
- R5: An instruction issues only if its target pipe still has a free slot after the earlier issues of the same cycle have been taken from that pipe's `free_slots` count.
- R6: With `diff_units` set, an instruction may not target the unit type of the instruction issued just before it in the same cycle. With `diff_units` clear, two issues may share a pipe. The record of the previous unit starts empty every cycle.
- R7: Nothing issues while `warp_waiting` is high. Examination stops at the first invalid head entry and at the first instruction that fails to issue, so a later slot never issues after an earlier one failed.
- R8: At most `max_issue` instructions issue per cycle. A value of 0 acts as 1, and values above the slot count act as the slot count.
- R9: `pop_cnt` equals the number of instructions issued in the current cycle. After the next rising edge, `iss_valid`, `iss_unit` and `iss_payload` show exactly those slots, and non-issued slots read as zero. `iss_mask` carries `warp_mask` when anything issued and zero otherwise.
- R10: While `rst_n` is low, all registered outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_waiting | input | 1 | Warp is blocked; no issue this cycle |
| head_valid | input | ISSUE_W (2) | Valid flags of the buffer head window, slot 0 oldest |
| head_op | input | ISSUE_W x 3 | Operation class per head entry |
| head_payload | input | ISSUE_W x PAY_W (16) | Instruction payload per head entry |
| warp_mask | input | LANES (32) | Active thread mask of the warp |
| free_slots | input | 4 x SLOT_W (2) | Free input slots per pipe, indexed by unit code |
| dp_unit_count | input | DPC_W (4) | Configured number of double-precision units |
| max_issue | input | SLOT_W (2) | Per-cycle issue limit |
| diff_units | input | 1 | Forbid consecutive issues to the same unit type |
| pop_cnt | output | SLOT_W (2) | Entries issued this cycle, combinational |
| iss_valid | output | ISSUE_W (2) | Registered issue strobe per slot |
| iss_unit | output | ISSUE_W x 2 | Registered target unit code per slot |
| iss_payload | output | ISSUE_W x PAY_W (16) | Registered payload per slot |
| iss_mask | output | LANES (32) | Registered active mask of the issued group |

## Verification
`pop_cnt` is combinational and belongs to the same cycle as the inputs that produce it. The strobes, units, payloads and mask come out of one register stage and are due one rising edge later. The bench changes inputs on the falling edge and reads `pop_cnt` one time unit afterwards, before any edge has passed. It then waits for the rising edge and samples the registered outputs at the following falling edge, so every comparison falls in the cycle its result is due. Each directed case sets the full input pattern at once, so the registered outputs reflect only that case.

// File: rtl/issue_router_pkg.sv
package issue_router_pkg;

  localparam int OP_W      = 3;
  localparam int UNIT_W    = 2;
  localparam int NUM_PIPES = 4;

  // operation class encodings
  localparam logic [OP_W-1:0] OPC_ALU     = 3'd0;
  localparam logic [OP_W-1:0] OPC_SFU     = 3'd1;
  localparam logic [OP_W-1:0] OPC_ALU_SFU = 3'd2;
  localparam logic [OP_W-1:0] OPC_DP      = 3'd3;
  localparam logic [OP_W-1:0] OPC_MEM     = 3'd4;

  // unit codes; the low two bits index the pipes
  typedef enum logic [2:0] {
    U_SP   = 3'd0,
    U_DP   = 3'd1,
    U_SFU  = 3'd2,
    U_MEM  = 3'd3,
    U_NONE = 3'd4
  } unit_e;

  // target pipe of an operation class; sp_open is the combined-class preference
  function automatic unit_e pick_unit(input logic [OP_W-1:0] op,
                                      input logic dp_present,
                                      input logic sp_open);
    unit_e u;
    case (op)
      OPC_MEM:     u = U_MEM;
      OPC_DP:      u = dp_present ? U_DP : U_SFU;
      OPC_SFU:     u = U_SFU;
      OPC_ALU_SFU: u = sp_open ? U_SP : U_SFU;
      default:     u = U_SP;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/issue_slot_route.sv
module issue_slot_route
  import issue_router_pkg::*;
#(
  parameter int SLOT_W = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                go_in,
  input  logic                                head_ok,
  input  logic                                in_window,
  input  logic                                waiting,
  input  logic                                dp_present,
  input  logic                                diff_mode,
  input  logic [OP_W-1:0]                     op,
  input  logic [NUM_PIPES-1:0][SLOT_W-1:0]    free_slots,
  input  logic [NUM_PIPES-1:0][SLOT_W-1:0]    used_in,
  input  unit_e                               prev_in,
  output logic                                fire,
  output logic                                go_out,
  output unit_e                               unit,
  output logic [NUM_PIPES-1:0][SLOT_W-1:0]    used_out,
  output unit_e                               prev_out
);

  logic                 examine;
  logic [NUM_PIPES-1:0] room;
  logic [NUM_PIPES-1:0] allow;
  logic [UNIT_W-1:0]    tgt_idx;

  always_comb begin
    for (int p = 0; p < NUM_PIPES; p++) begin
      room[p]  = free_slots[p] > used_in[p];
      allow[p] = !diff_mode || (prev_in != unit_e'(3'(p)));
    end
  end

  always_comb begin
    unit     = pick_unit(op, dp_present, room[U_SP] && allow[U_SP]);
    tgt_idx  = unit[UNIT_W-1:0];
    examine  = go_in && head_ok && in_window && !waiting;
    fire     = examine && room[tgt_idx] && allow[tgt_idx];
    go_out   = fire;
    used_out = used_in;
    if (fire) used_out[tgt_idx] = used_in[tgt_idx] + SLOT_W'(1);
    prev_out = fire ? unit : prev_in;
  end

  assert_no_fire_waiting_R7: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !fire);

  assert_no_fire_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !go_in |-> !fire);

endmodule

// File: rtl/issue_out_stage.sv
module issue_out_stage
  import issue_router_pkg::*;
#(
  parameter int ISSUE_W = 2,
  parameter int PAY_W   = 16,
  parameter int LANES   = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ISSUE_W-1:0]               fire,
  input  logic [ISSUE_W-1:0][UNIT_W-1:0]   unit_in,
  input  logic [ISSUE_W-1:0][PAY_W-1:0]    payload_in,
  input  logic [LANES-1:0]                 mask_in,
  output logic [ISSUE_W-1:0]               iss_valid,
  output logic [ISSUE_W-1:0][UNIT_W-1:0]   iss_unit,
  output logic [ISSUE_W-1:0][PAY_W-1:0]    iss_payload,
  output logic [LANES-1:0]                 iss_mask
);

  for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        iss_valid[s]   <= 1'b0;
        iss_unit[s]    <= '0;
        iss_payload[s] <= '0;
      end else begin
        iss_valid[s]   <= fire[s];
        iss_unit[s]    <= fire[s] ? unit_in[s] : '0;
        iss_payload[s] <= fire[s] ? payload_in[s] : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) iss_mask <= '0;
    else        iss_mask <= (|fire) ? mask_in : '0;
  end

  assert_reset_clear_R10: assert property (@(posedge clk)
    !rst_n |=> (iss_valid == '0) && (iss_mask == '0));

endmodule

// File: rtl/warp_issue_router.sv
module warp_issue_router
  import issue_router_pkg::*;
#(
  parameter int ISSUE_W = 2,
  parameter int PAY_W   = 16,
  parameter int LANES   = 32,
  parameter int DPC_W   = 4,
  localparam int SLOT_W = $clog2(ISSUE_W + 1)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               warp_waiting,
  input  logic [ISSUE_W-1:0]                 head_valid,
  input  logic [ISSUE_W-1:0][OP_W-1:0]       head_op,
  input  logic [ISSUE_W-1:0][PAY_W-1:0]      head_payload,
  input  logic [LANES-1:0]                   warp_mask,
  input  logic [NUM_PIPES-1:0][SLOT_W-1:0]   free_slots,
  input  logic [DPC_W-1:0]                   dp_unit_count,
  input  logic [SLOT_W-1:0]                  max_issue,
  input  logic                               diff_units,
  output logic [SLOT_W-1:0]                  pop_cnt,
  output logic [ISSUE_W-1:0]                 iss_valid,
  output logic [ISSUE_W-1:0][UNIT_W-1:0]     iss_unit,
  output logic [ISSUE_W-1:0][PAY_W-1:0]      iss_payload,
  output logic [LANES-1:0]                   iss_mask
);

  // effective per-cycle limit, clamped into 1..ISSUE_W
  function automatic logic [SLOT_W-1:0] clamp_limit(input logic [SLOT_W-1:0] m);
    if (m == '0) return SLOT_W'(1);
    if (int'(m) > ISSUE_W) return SLOT_W'(ISSUE_W);
    return m;
  endfunction

  function automatic logic [SLOT_W-1:0] count_set(input logic [ISSUE_W-1:0] v);
    logic [SLOT_W-1:0] c = '0;
    for (int i = 0; i < ISSUE_W; i++) c = c + SLOT_W'(v[i]);
    return c;
  endfunction

  logic                                dp_present;
  logic [SLOT_W-1:0]                   limit_eff;
  logic [ISSUE_W:0]                    chain_go;
  unit_e                               chain_prev [ISSUE_W+1];
  logic [NUM_PIPES-1:0][SLOT_W-1:0]    chain_used [ISSUE_W+1];
  logic [ISSUE_W-1:0]                  slot_fire;
  unit_e                               slot_unit  [ISSUE_W];
  logic [ISSUE_W-1:0][UNIT_W-1:0]      slot_code;

  assign dp_present    = dp_unit_count != '0;
  assign limit_eff     = clamp_limit(max_issue);
  assign chain_go[0]   = 1'b1;
  assign chain_prev[0] = U_NONE;
  assign chain_used[0] = '0;

  for (genvar s = 0; s < ISSUE_W; s++) begin : g_chain
    issue_slot_route #(.SLOT_W(SLOT_W)) u_route (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_in      (chain_go[s]),
      .head_ok    (head_valid[s]),
      .in_window  (SLOT_W'(s) < limit_eff),
      .waiting    (warp_waiting),
      .dp_present (dp_present),
      .diff_mode  (diff_units),
      .op         (head_op[s]),
      .free_slots (free_slots),
      .used_in    (chain_used[s]),
      .prev_in    (chain_prev[s]),
      .fire       (slot_fire[s]),
      .go_out     (chain_go[s+1]),
      .unit       (slot_unit[s]),
      .used_out   (chain_used[s+1]),
      .prev_out   (chain_prev[s+1])
    );
    assign slot_code[s] = slot_unit[s][UNIT_W-1:0];
  end

  assign pop_cnt = count_set(slot_fire);

  issue_out_stage #(.ISSUE_W(ISSUE_W), .PAY_W(PAY_W), .LANES(LANES)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (slot_fire),
    .unit_in     (slot_code),
    .payload_in  (head_payload),
    .mask_in     (warp_mask),
    .iss_valid   (iss_valid),
    .iss_unit    (iss_unit),
    .iss_payload (iss_payload),
    .iss_mask    (iss_mask)
  );

  // per-pipe issue counts seen at the outputs
  logic [NUM_PIPES-1:0][SLOT_W-1:0] out_pipe_cnt;
  always_comb begin
    for (int p = 0; p < NUM_PIPES; p++) begin
      out_pipe_cnt[p] = '0;
      for (int s = 0; s < ISSUE_W; s++)
        if (iss_valid[s] && iss_unit[s] == UNIT_W'(p))
          out_pipe_cnt[p] = out_pipe_cnt[p] + SLOT_W'(1);
    end
  end

  assert_pop_matches_strobes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> count_set(iss_valid) == $past(pop_cnt));

  assert_limit_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_cnt <= limit_eff);

  assert_dp_fallback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_unit_count == '0) |=> out_pipe_cnt[U_DP] == '0);

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_room_chk
    assert_room_respected_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> out_pipe_cnt[p] <= $past(free_slots[p]));
  end

  for (genvar s = 1; s < ISSUE_W; s++) begin : g_order_chk
    assert_in_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[s] |-> iss_valid[s-1]);
    assert_diff_units_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (diff_units && slot_fire[s]) |=> iss_unit[s] != iss_unit[s-1]);
  end

endmodule

// File: tb/sim_warp_issue_router.sv
module sim_warp_issue_router;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MASK = 32'hC3A5_0F96;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              warp_waiting = 1'b0;
  logic [1:0]        head_valid = '0;
  logic [1:0][2:0]   head_op = '0;
  logic [1:0][15:0]  head_payload = '0;
  logic [31:0]       warp_mask = MASK;
  logic [3:0][1:0]   free_slots = '0;
  logic [3:0]        dp_unit_count = '0;
  logic [1:0]        max_issue = 2'd2;
  logic              diff_units = 1'b0;
  logic [1:0]        pop_cnt;
  logic [1:0]        iss_valid;
  logic [1:0][1:0]   iss_unit;
  logic [1:0][15:0]  iss_payload;
  logic [31:0]       iss_mask;

  int total = 0;
  int bad = 0;
  int case_no = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_issue_router u0 (
    .clk(clk), .rst_n(rst_n), .warp_waiting(warp_waiting),
    .head_valid(head_valid), .head_op(head_op), .head_payload(head_payload),
    .warp_mask(warp_mask), .free_slots(free_slots), .dp_unit_count(dp_unit_count),
    .max_issue(max_issue), .diff_units(diff_units), .pop_cnt(pop_cnt),
    .iss_valid(iss_valid), .iss_unit(iss_unit), .iss_payload(iss_payload),
    .iss_mask(iss_mask)
  );

  function automatic logic [3:0][1:0] fs(int sp, int dp, int sfu, int mem);
    logic [3:0][1:0] f;
    f[0] = 2'(sp); f[1] = 2'(dp); f[2] = 2'(sfu); f[3] = 2'(mem);
    return f;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one cycle of stimulus, then same-cycle and next-edge checks
  task automatic run_case(string tag, logic wt, logic [1:0] hv, logic [2:0] o0,
                          logic [2:0] o1, logic [3:0][1:0] fr, logic [3:0] dpc,
                          logic [1:0] mx, logic df, int e_pop, logic [1:0] e_v,
                          logic [1:0] e_u0, logic [1:0] e_u1);
    logic [15:0] p0, p1;
    case_no++;
    p0 = 16'h1000 + 16'(case_no);
    p1 = 16'h2000 + 16'(case_no);
    @(negedge clk);
    warp_waiting = wt; head_valid = hv; head_op[0] = o0; head_op[1] = o1;
    head_payload[0] = p0; head_payload[1] = p1; free_slots = fr;
    dp_unit_count = dpc; max_issue = mx; diff_units = df;
    #1;
    chk(tag, "pop_cnt", pop_cnt, e_pop);
    @(posedge clk);
    @(negedge clk);
    chk(tag, "iss_valid", iss_valid, e_v);
    chk(tag, "iss_unit0", iss_unit[0], e_v[0] ? e_u0 : 2'd0);
    chk(tag, "iss_unit1", iss_unit[1], e_v[1] ? e_u1 : 2'd0);
    chk(tag, "iss_payload0", iss_payload[0], e_v[0] ? p0 : 16'h0);
    chk(tag, "iss_payload1", iss_payload[1], e_v[1] ? p1 : 16'h0);
    chk(tag, "iss_mask", iss_mask, (e_v != 2'b00) ? MASK : 32'h0);
  endtask

  task automatic t_reset_R10;
    head_valid = 2'b11; free_slots = fs(2, 2, 2, 2); dp_unit_count = 4'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "iss_valid", iss_valid, 0);
    chk("R10", "iss_payload", iss_payload, 0);
    chk("R10", "iss_mask", iss_mask, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_plain_mem_R1;
    run_case("R1", 0, 2'b11, 3'd0, 3'd4, fs(1, 0, 0, 1), 4'd1, 2'd2, 0, 2, 2'b11, 2'd0, 2'd3);
    run_case("R1", 0, 2'b01, 3'd7, 3'd0, fs(1, 0, 0, 0), 4'd1, 2'd2, 0, 1, 2'b01, 2'd0, 2'd0);
  endtask

  task automatic t_dp_present_R2;
    run_case("R2", 0, 2'b11, 3'd3, 3'd3, fs(0, 2, 0, 0), 4'd2, 2'd2, 0, 2, 2'b11, 2'd1, 2'd1);
  endtask

  task automatic t_dp_absent_R3;
    run_case("R3", 0, 2'b11, 3'd3, 3'd1, fs(0, 2, 2, 0), 4'd0, 2'd2, 0, 2, 2'b11, 2'd2, 2'd2);
    run_case("R3", 0, 2'b01, 3'd3, 3'd0, fs(0, 2, 0, 0), 4'd0, 2'd2, 0, 0, 2'b00, 2'd0, 2'd0);
  endtask

  task automatic t_combined_R4;
    run_case("R4", 0, 2'b11, 3'd2, 3'd2, fs(1, 0, 1, 0), 4'd1, 2'd2, 0, 2, 2'b11, 2'd0, 2'd2);
    run_case("R4", 0, 2'b01, 3'd2, 3'd0, fs(0, 0, 1, 0), 4'd1, 2'd2, 0, 1, 2'b01, 2'd2, 2'd0);
    run_case("R4", 0, 2'b11, 3'd0, 3'd2, fs(2, 0, 1, 0), 4'd1, 2'd2, 1, 2, 2'b11, 2'd0, 2'd2);
  endtask

  task automatic t_backpressure_R5;
    run_case("R5", 0, 2'b11, 3'd0, 3'd0, fs(1, 0, 0, 0), 4'd1, 2'd2, 0, 1, 2'b01, 2'd0, 2'd0);
    run_case("R5", 0, 2'b01, 3'd4, 3'd0, fs(1, 1, 1, 0), 4'd1, 2'd2, 0, 0, 2'b00, 2'd0, 2'd0);
    run_case("R5", 0, 2'b01, 3'd3, 3'd0, fs(1, 0, 1, 1), 4'd1, 2'd2, 0, 0, 2'b00, 2'd0, 2'd0);
    run_case("R5", 0, 2'b01, 3'd1, 3'd0, fs(1, 1, 0, 1), 4'd1, 2'd2, 0, 0, 2'b00, 2'd0, 2'd0);
  endtask

  task automatic t_same_unit_R6;
    run_case("R6", 0, 2'b11, 3'd0, 3'd0, fs(2, 0, 0, 0), 4'd1, 2'd2, 1, 1, 2'b01, 2'd0, 2'd0);
    run_case("R6", 0, 2'b11, 3'd0, 3'd0, fs(2, 0, 0, 0), 4'd1, 2'd2, 0, 2, 2'b11, 2'd0, 2'd0);
    run_case("R6", 0, 2'b11, 3'd4, 3'd4, fs(0, 0, 0, 2), 4'd1, 2'd2, 1, 1, 2'b01, 2'd3, 2'd0);
  endtask

  task automatic t_stop_R7;
    run_case("R7", 1, 2'b11, 3'd0, 3'd4, fs(2, 2, 2, 2), 4'd1, 2'd2, 0, 0, 2'b00, 2'd0, 2'd0);
    run_case("R7", 0, 2'b11, 3'd0, 3'd4, fs(0, 2, 2, 1), 4'd1, 2'd2, 0, 0, 2'b00, 2'd0, 2'd0);
    run_case("R7", 0, 2'b01, 3'd0, 3'd4, fs(2, 2, 2, 2), 4'd1, 2'd2, 0, 1, 2'b01, 2'd0, 2'd0);
  endtask

  task automatic t_limit_R8;
    run_case("R8", 0, 2'b11, 3'd0, 3'd4, fs(1, 0, 0, 1), 4'd1, 2'd1, 0, 1, 2'b01, 2'd0, 2'd0);
    run_case("R8", 0, 2'b11, 3'd0, 3'd4, fs(1, 0, 0, 1), 4'd1, 2'd0, 0, 1, 2'b01, 2'd0, 2'd0);
    run_case("R8", 0, 2'b11, 3'd0, 3'd4, fs(1, 0, 0, 1), 4'd1, 2'd3, 0, 2, 2'b11, 2'd0, 2'd3);
  endtask

  task automatic t_idle_R9;
    run_case("R9", 0, 2'b00, 3'd0, 3'd0, fs(2, 2, 2, 2), 4'd1, 2'd2, 0, 0, 2'b00, 2'd0, 2'd0);
  endtask

  initial begin
    t_reset_R10();
    t_plain_mem_R1();
    t_dp_present_R2();
    t_dp_absent_R3();
    t_combined_R4();
    t_backpressure_R5();
    t_same_unit_R6();
    t_stop_R7();
    t_limit_R8();
    t_idle_R9();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule